// File: doc/BRIEF.md
# Endpoint Memory Window Register File and Address Decoder

This block holds the six 32-bit memory base registers of an endpoint's configuration header. It also decides which of the windows they describe an incoming memory request falls into. Configuration software reaches the registers through a dword-addressed read/write port that covers the 256-byte header. The six registers occupy dwords 4 through 9, which are byte offsets 10h, 14h, 18h, 1Ch, 20h and 24h.

Each window's size is a power of two and is fixed when the block is built. Address bits below the size cannot be written. Software finds the size by writing all ones to a register and reading it back: only the programmable upper bits come back as ones. Once the bases are programmed, every request address is compared against each implemented window on its upper bits only. The decoder reports a hit with the window index and the in-window offset, or a miss.

Top module: `bar_decoder`

## Requirements
- R1: The registers for window i (i = 0..5) sit at configuration dword 4+i. A read of any other dword returns zero, and a write to any other dword changes nothing. Reads are combinational on `cfg_addr`. Writes take effect at the clock edge where `cfg_wr` is high.
- R2: For a window of 2^n bytes, bits 31..n are writable and bits n-1..0 read as zero apart from the attribute nibble. Writing FFFF_FFFFh to a 128 MB window reads back F800_0000h, and to a 64 MB window reads back FC00_0000h.
- R3: Bits 3..0 of an implemented register are read-only and read as {prefetchable, 0, 0, 0}, where the prefetchable bit comes from the window's build parameter. Bit 0 = 0 marks memory space and bits 2:1 = 00 mark a 32-bit window.
- R4: A window built with size code 0 is not implemented and reads back as 00000000h whatever is written to it.
- R5: `cfg_be[k]` enables byte k (bits 8k+7..8k) of a write. Disabled bytes keep their previous value.
- R6: After reset, every writable bit is zero, so a register reads only its attribute nibble.
- R7: A request presented with `req_valid` produces `dec_valid` high in the next cycle. `dec_hit` is high when the request's bits 31..n equal the programmed base bits 31..n of some implemented window.
- R8: On a hit, `dec_off` carries request bits n-1..0 of the matching window, and all higher bits are zero.
- R9: A request that matches no implemented window gives `dec_miss` high and `dec_hit` low. `dec_hit` and `dec_miss` are never high together.
- R10: When several windows match, `dec_idx` reports the lowest-numbered one, and the offset uses that window's size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration dword address within the header |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| req_valid | input | 1 | Memory request address valid |
| req_addr | input | 32 | Memory request address |
| dec_valid | output | 1 | Decode result valid, one cycle after the request |
| dec_hit | output | 1 | Request fell into an implemented window |
| dec_miss | output | 1 | Request matched no window |
| dec_idx | output | 3 | Index of the winning window |
| dec_off | output | 32 | Offset inside the winning window |

## Verification
The bench builds the block with windows of 2^27, 2^26, 2^12 and 2^4 bytes on indices 0, 1, 2 and 4, and leaves indices 3 and 5 unimplemented. Window 1 is marked prefetchable. This mix puts the examples from the requirements (F800_0000h and FC00_0000h) within reach, along with the smallest legal window and unimplemented slots. The 16-byte window can be placed inside the 128 MB one, which lets the priority rule of R10 be exercised. Byte enables are tried on a window whose mask boundary lies inside a byte lane.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;
  localparam int unsigned NBAR     = 6;   // windows in the header
  localparam int unsigned FIRST_DW = 4;   // dword of window 0 (byte 10h)
  localparam int unsigned CFG_AW   = 6;   // dword address bits of 256-byte header
  localparam int unsigned AW       = 32;  // request and register width
  localparam int unsigned IDX_W    = $clog2(NBAR);
  localparam int unsigned LOG_W    = 6;   // width of a size code

  typedef logic [AW-1:0] addr_t;

  // Writable-bit mask for a window of 2^lg bytes; lg == 0 means absent.
  function automatic addr_t win_mask(input int unsigned lg);
    if (lg == 0) return '0;
    return ~((addr_t'(1) << lg) - addr_t'(1));
  endfunction

  // Expand four byte enables to a bit mask.
  function automatic addr_t be_bits(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction
endpackage

// File: rtl/bar_reg_slice.sv
module bar_reg_slice
  import bar_dec_pkg::*;
#(
  parameter int unsigned SIZE_LOG2 = 12,
  parameter bit          PREFETCH  = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_be,
  input  addr_t       wr_data,
  input  addr_t       req_addr,
  output addr_t       rd_value,
  output logic        match
);
  localparam bit    IMPL  = (SIZE_LOG2 != 0);
  localparam addr_t WMASK = win_mask(SIZE_LOG2);
  localparam addr_t ATTR  = (IMPL && PREFETCH) ? addr_t'(8) : '0;

  addr_t base_q;
  addr_t base_d;
  addr_t upd_mask;

  // next-state
  always_comb begin
    upd_mask = WMASK & be_bits(wr_be);
    base_d   = base_q;
    if (wr_en) begin
      base_d = (base_q & ~upd_mask) | (wr_data & upd_mask);
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (wr_en) begin
      base_q <= base_d;
    end
  end

  assign rd_value = base_q | ATTR;
  assign match    = IMPL && ((req_addr & WMASK) == base_q);
endmodule

// File: rtl/bar_cfg_port.sv
module bar_cfg_port
  import bar_dec_pkg::*;
(
  input  logic                  cfg_wr,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  addr_t [NBAR-1:0]      bar_vals,
  output logic  [NBAR-1:0]      wr_sel,
  output addr_t                 cfg_rdata
);
  logic [NBAR-1:0] hit_dw;

  genvar gi;
  generate
    for (gi = 0; gi < NBAR; gi++) begin : g_sel
      assign hit_dw[gi] = (cfg_addr == CFG_AW'(FIRST_DW + gi));
      assign wr_sel[gi] = cfg_wr && hit_dw[gi];
    end
  endgenerate

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NBAR; i++) begin
      if (hit_dw[i]) cfg_rdata = cfg_rdata | bar_vals[i];
    end
  end
endmodule

// File: rtl/bar_match_arb.sv
module bar_match_arb
  import bar_dec_pkg::*;
#(
  parameter logic [NBAR-1:0][LOG_W-1:0] BAR_LOG2 = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  addr_t             req_addr,
  input  logic [NBAR-1:0]   match,
  output logic              dec_valid,
  output logic              dec_hit,
  output logic              dec_miss,
  output logic [IDX_W-1:0]  dec_idx,
  output addr_t             dec_off
);
  logic              v_d, hit_d, miss_d;
  logic [IDX_W-1:0]  idx_d;
  addr_t             off_d, omask;

  // next-state: scan downward so the lowest index is written last
  always_comb begin
    idx_d = '0;
    omask = '0;
    for (int i = NBAR - 1; i >= 0; i--) begin
      if (match[i]) begin
        idx_d = IDX_W'(i);
        omask = ~win_mask(int'(BAR_LOG2[i]));
      end
    end
    v_d    = req_valid;
    hit_d  = req_valid && (|match);
    miss_d = req_valid && !(|match);
    off_d  = hit_d ? (req_addr & omask) : '0;
    if (!hit_d) idx_d = '0;
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_hit   <= 1'b0;
      dec_miss  <= 1'b0;
      dec_idx   <= '0;
      dec_off   <= '0;
    end else begin
      dec_valid <= v_d;
      dec_hit   <= hit_d;
      dec_miss  <= miss_d;
      dec_idx   <= idx_d;
      dec_off   <= off_d;
    end
  end
endmodule

// File: rtl/bar_decoder.sv
module bar_decoder
  import bar_dec_pkg::*;
#(
  // size codes per window, index 0 in the low slot; 0 = absent, else 4..31
  parameter logic [NBAR-1:0][LOG_W-1:0] BAR_LOG2 =
    {6'd0, 6'd4, 6'd0, 6'd12, 6'd26, 6'd27},
  parameter logic [NBAR-1:0]            BAR_PREF = 6'b000010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [5:0]        cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  output logic              dec_valid,
  output logic              dec_hit,
  output logic              dec_miss,
  output logic [2:0]        dec_idx,
  output logic [31:0]       dec_off
);
  addr_t [NBAR-1:0] bar_vals;
  logic  [NBAR-1:0] wr_sel;
  logic  [NBAR-1:0] match;

  bar_cfg_port u_port (
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .bar_vals  (bar_vals),
    .wr_sel    (wr_sel),
    .cfg_rdata (cfg_rdata)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NBAR; gi++) begin : g_bar
      bar_reg_slice #(
        .SIZE_LOG2 (int'(BAR_LOG2[gi])),
        .PREFETCH  (BAR_PREF[gi])
      ) u_slice (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_sel[gi]),
        .wr_be    (cfg_be),
        .wr_data  (cfg_wdata),
        .req_addr (req_addr),
        .rd_value (bar_vals[gi]),
        .match    (match[gi])
      );
    end
  endgenerate

  bar_match_arb #(.BAR_LOG2(BAR_LOG2)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .match     (match),
    .dec_valid (dec_valid),
    .dec_hit   (dec_hit),
    .dec_miss  (dec_miss),
    .dec_idx   (dec_idx),
    .dec_off   (dec_off)
  );
endmodule

// File: rtl/bar_dec_chk.sv
module bar_dec_chk
  import bar_dec_pkg::*;
#(
  parameter logic [NBAR-1:0][LOG_W-1:0] BAR_LOG2 = '0
) (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  cfg_addr,
  input logic [31:0] cfg_rdata,
  input logic        req_valid,
  input logic        dec_valid,
  input logic        dec_hit,
  input logic        dec_miss,
  input logic [2:0]  dec_idx,
  input logic [31:0] dec_off
);
  logic in_bar;
  assign in_bar = (cfg_addr >= 6'(FIRST_DW)) && (cfg_addr < 6'(FIRST_DW + NBAR));

  // R1
  outside_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_bar |-> cfg_rdata == 32'h0);
  // R3
  attr_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_bar |-> cfg_rdata[2:0] == 3'b000);
  // R7
  req_then_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> dec_valid);
  // R7
  result_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_hit || dec_miss) |-> $past(req_valid));
  // R9
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_hit && dec_miss));
  // R8
  off_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_hit && dec_idx < 3'(NBAR)) |->
      (dec_off & win_mask(int'(BAR_LOG2[dec_idx]))) == 32'h0);
  // R10
  idx_implemented_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit |-> (dec_idx < 3'(NBAR)) && (BAR_LOG2[dec_idx] != '0));
endmodule

bind bar_decoder bar_dec_chk #(.BAR_LOG2(BAR_LOG2)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata),
  .req_valid (req_valid),
  .dec_valid (dec_valid),
  .dec_hit   (dec_hit),
  .dec_miss  (dec_miss),
  .dec_idx   (dec_idx),
  .dec_off   (dec_off)
);

// File: tb/bar_decoder_test.sv
module bar_decoder_test;
  localparam int SZ [6] = '{27, 26, 12, 0, 4, 0};
  localparam bit PF [6] = '{0, 1, 0, 0, 0, 0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        dec_valid, dec_hit, dec_miss;
  logic [2:0]  dec_idx;
  logic [31:0] dec_off;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  bar_decoder #(
    .BAR_LOG2({6'd0, 6'd4, 6'd0, 6'd12, 6'd26, 6'd27}),
    .BAR_PREF(6'b000010)
  ) uut (.*);

  function automatic logic [31:0] msk(int i);
    if (SZ[i] == 0) return 32'h0;
    return ~((32'h1 << SZ[i]) - 32'h1);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_base [6];
  logic        e_valid, e_hit, e_miss;
  logic [2:0]  e_idx;
  logic [31:0] e_off;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_base[i]) m_base[i] = 32'h0;
      e_valid = 0; e_hit = 0; e_miss = 0; e_idx = 0; e_off = 0;
    end else begin
      e_valid = req_valid; e_hit = 0; e_miss = 0; e_idx = 0; e_off = 0;
      if (req_valid) begin
        for (int i = 5; i >= 0; i--) begin
          if (SZ[i] != 0 && (req_addr & msk(i)) == m_base[i]) begin
            e_hit = 1; e_idx = 3'(i); e_off = req_addr & ~msk(i);
          end
        end
        e_miss = !e_hit;
      end
      if (cfg_wr && cfg_addr >= 4 && cfg_addr <= 9) begin
        automatic int k = int'(cfg_addr) - 4;
        automatic logic [31:0] bm = {{8{cfg_be[3]}}, {8{cfg_be[2]}}, {8{cfg_be[1]}}, {8{cfg_be[0]}}};
        bm = bm & msk(k);
        m_base[k] = (m_base[k] & ~bm) | (cfg_wdata & bm);
      end
    end
  end

  function automatic logic [31:0] m_read(logic [5:0] a);
    automatic int k;
    if (a < 4 || a > 9) return 32'h0;
    k = int'(a) - 4;
    if (SZ[k] == 0) return 32'h0;
    return m_base[k] | (PF[k] ? 32'h8 : 32'h0);
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 rdata model", cfg_rdata, m_read(cfg_addr));
      chk("R7 valid model", 32'(dec_valid), 32'(e_valid));
      chk("R7 hit model", 32'(dec_hit), 32'(e_hit));
      chk("R9 miss model", 32'(dec_miss), 32'(e_miss));
      if (e_hit) begin
        chk("R10 idx model", 32'(dec_idx), 32'(e_idx));
        chk("R8 off model", dec_off, e_off);
      end
    end
  end

  task automatic cfg_write(logic [5:0] a, logic [31:0] d, logic [3:0] be);
    @(posedge clk); #2;
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
    @(posedge clk); #2;
    cfg_wr = 0;
  endtask

  task automatic cfg_read(logic [5:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #2;
    cfg_addr = a;
    @(negedge clk);
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic req(logic [31:0] a, bit hit, int idx, logic [31:0] off, string tag);
    @(posedge clk); #2;
    req_valid = 1; req_addr = a;
    @(posedge clk); #2;
    req_valid = 0;
    @(negedge clk);
    chk({tag, " valid"}, 32'(dec_valid), 32'h1);
    chk({tag, " hit"}, 32'(dec_hit), 32'(hit));
    chk({tag, " miss"}, 32'(dec_miss), 32'(!hit));
    if (hit) begin
      chk({tag, " idx"}, 32'(dec_idx), 32'(idx));
      chk({tag, " off"}, dec_off, off);
    end
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R6 reset values, R3 attribute nibble
    cfg_read(6'd4, 32'h0000_0000, "R6 window0 reset");
    cfg_read(6'd5, 32'h0000_0008, "R3 window1 prefetch nibble");
    cfg_read(6'd8, 32'h0000_0000, "R6 window4 reset");
    // R2 size discovery
    for (int i = 4; i <= 9; i++) cfg_write(6'(i), 32'hFFFF_FFFF, 4'hF);
    cfg_read(6'd4, 32'hF800_0000, "R2 128MB mask");
    cfg_read(6'd5, 32'hFC00_0008, "R2 64MB mask");
    cfg_read(6'd6, 32'hFFFF_F000, "R2 4KB mask");
    cfg_read(6'd8, 32'hFFFF_FFF0, "R2 16B mask");
    // R4 unimplemented
    cfg_read(6'd7, 32'h0000_0000, "R4 window3 absent");
    cfg_read(6'd9, 32'h0000_0000, "R4 window5 absent");
    // R1 non-window dwords
    cfg_write(6'd3, 32'hFFFF_FFFF, 4'hF);
    cfg_read(6'd3, 32'h0000_0000, "R1 dword3");
    cfg_write(6'd10, 32'hFFFF_FFFF, 4'hF);
    cfg_read(6'd10, 32'h0000_0000, "R1 dword10");
    cfg_read(6'd4, 32'hF800_0000, "R1 window0 untouched");
    // R5 byte enables
    cfg_write(6'd6, 32'h1234_5678, 4'b0101);
    cfg_read(6'd6, 32'hFF34_F000, "R5 lanes 0 and 2");
    // program bases
    cfg_write(6'd4, 32'h2000_0000, 4'hF);
    cfg_write(6'd5, 32'h3800_0000, 4'hF);
    cfg_write(6'd6, 32'h5000_0000, 4'hF);
    cfg_write(6'd8, 32'h2000_0100, 4'hF);
    cfg_read(6'd4, 32'h2000_0000, "R2 base0 readback");
    // R7/R8 hits, R9 misses, R10 overlap
    req(32'h2000_0000, 1, 0, 32'h0000_0000, "R7 base0 low edge");
    req(32'h27FF_FFFF, 1, 0, 32'h07FF_FFFF, "R8 base0 high edge");
    req(32'h2800_0000, 0, 0, 32'h0, "R9 above window0");
    req(32'h3BFF_FFFC, 1, 1, 32'h03FF_FFFC, "R8 window1");
    req(32'h5000_0ABC, 1, 2, 32'h0000_0ABC, "R8 window2");
    req(32'h1000_0000, 0, 0, 32'h0, "R9 unmapped");
    req(32'h2000_0104, 1, 0, 32'h0000_0104, "R10 overlap 0 vs 4");
    cfg_write(6'd8, 32'h6000_0010, 4'hF);
    req(32'h6000_001F, 1, 4, 32'h0000_000F, "R8 16B window");
    req(32'h6000_0020, 0, 0, 32'h0, "R9 past 16B window");
    @(posedge clk); #2;
    req_valid = 0;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule